// File: doc/BRIEF.md
# Folded SRAM Array with Column Multiplexing

This block is a behavioural, synthesizable static memory of 2^n words, each 2^m bits wide, laid out the way a real array is. The words are folded into 2^(n-k) physical rows of 2^(m+k) bits. Each row interleaves 2^k words, so bit j of word w is stored in row w>>k at column j*2^k + (w mod 2^k).

A word address splits into two fields. The high n-k bits form the row field. A predecoded row decoder turns it into a single word-line. The low k bits form the column field. It steers a 2^k:1 multiplexer in every bit group, and it is decoded in parallel with the row.

Every access takes two phases, run as a two-state machine:

- **PRECH** (precharge): the bit-lines are held high and no word-line is raised. The block is ready for a request in this state.
- **ACCESS**: the addressed word-line is asserted. The read is sensed, the write is merged into the selected columns, and the machine returns to PRECH.

There are two transitions:

- **PRECH→ACCESS** is taken when a request is accepted.
- **ACCESS→PRECH** is always taken after one cycle.

Read data is registered and appears in the cycle after the access phase.

Top module: `folded_sram`

## Requirements
- R1: After reset, req_ready is 1, rd_valid is 0, rd_data is 0, every stored word reads back as 0, and no word-line is asserted.
- R2: req_ready is 1 only in the precharge phase. A request is accepted on a rising edge where req_valid and req_ready are both 1. That edge moves the block into the access phase for exactly one cycle, with req_ready at 0, after which it returns to precharge.
- R3: A request presented while req_ready is 0 is ignored: it writes nothing and produces no read.
- R4: For an accepted request with req_rd=1, rd_valid is 1 for exactly the one cycle that follows the access phase, and rd_data carries the word. rd_data holds its value at all other times.
- R5: A word written to an address is returned by a later read of that address, for every address.
- R6: A write changes only the addressed word. The other words that share its physical row (same address bits above the low k bits) keep their values.
- R7: A request with both req_wr=1 and req_rd=1 returns the word held before the request, and stores the new word for later reads.
- R8: During the access phase, word_line has exactly one bit set, at index req_addr>>k of the accepted request. During precharge, word_line is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_wr | input | 1 | Request writes req_wdata |
| req_rd | input | 1 | Request reads the addressed word |
| req_addr | input | ADDR_W (3) | Word address: row field in the high bits, column field in the low COL_LOG bits |
| req_wdata | input | 2^DATA_LOG (4) | Write word |
| req_ready | output | 1 | High in the precharge phase, when a request can be accepted |
| word_line | output | 2^(ADDR_W-COL_LOG) (4) | Row select lines, one-hot during access |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | 2^DATA_LOG (4) | Registered read word |

## Verification
A request is accepted on the edge where it is sampled with req_ready high. The following cycle is the access phase. In that cycle req_ready is low and word_line shows the addressed row. One edge later, rd_valid and rd_data carry the result, and req_ready is high again.

The bench model advances on the same rising edges using these delays. It compares every output at the falling edge, after the design's registers have settled, so each result is checked in exactly the cycle it is due.

// File: rtl/folded_sram_pkg.sv
package folded_sram_pkg;

    typedef enum logic [0:0] {
        PH_PRECH  = 1'b0,
        PH_ACCESS = 1'b1
    } phase_t;

endpackage

// File: rtl/row_predecoder.sv
module row_predecoder #(
    parameter int ROW_W = 2,
    localparam int ROWS   = 1 << ROW_W,
    localparam int GROUPS = (ROW_W + 1) / 2,
    localparam int PAD_W  = GROUPS * 2
) (
    input  logic             en,
    input  logic [ROW_W-1:0] row_addr,
    output logic [ROWS-1:0]  wl
);

    logic [PAD_W-1:0]             padded;
    logic [GROUPS-1:0][3:0]       pre;

    always_comb begin
        padded = '0;
        padded[ROW_W-1:0] = row_addr;
    end

    // each 2-bit slice of the row field is decoded to four partial-product lines
    for (genvar g = 0; g < GROUPS; g++) begin : g_pre
        always_comb begin
            pre[g] = 4'b0001 << padded[2*g +: 2];
        end
    end

    // each word-line is the AND of one line taken from every group
    for (genvar i = 0; i < ROWS; i++) begin : g_wl
        always_comb begin
            logic t;
            t = en;
            for (int g = 0; g < GROUPS; g++) begin
                t = t & pre[g][(i >> (2 * g)) & 3];
            end
            wl[i] = t;
        end
    end

endmodule

// File: rtl/bitline_array.sv
module bitline_array #(
    parameter int ROW_W    = 2,
    parameter int DATA_LOG = 2,
    parameter int COL_LOG  = 1,
    localparam int ROWS     = 1 << ROW_W,
    localparam int DATA_W   = 1 << DATA_LOG,
    localparam int COLS_PER = 1 << COL_LOG,
    localparam int ROW_BITS = DATA_W * COLS_PER
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ROWS-1:0]     wl,
    input  logic                we,
    input  logic [COL_LOG-1:0]  col,
    input  logic [DATA_W-1:0]   wdata,
    output logic [ROW_BITS-1:0] bl
);

    logic [ROW_BITS-1:0] cells [ROWS];

    // bit-lines sit high (precharged) and a selected cell storing 0 pulls its line low
    always_comb begin
        bl = '1;
        for (int r = 0; r < ROWS; r++) begin
            if (wl[r]) begin
                bl = bl & cells[r];
            end
        end
    end

    // write drivers reach only the columns picked by the column field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                cells[r] <= '0;
            end
        end else if (we) begin
            for (int r = 0; r < ROWS; r++) begin
                if (wl[r]) begin
                    for (int j = 0; j < DATA_W; j++) begin
                        cells[r][j*COLS_PER + int'(col)] <= wdata[j];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/column_mux.sv
module column_mux #(
    parameter int DATA_LOG = 2,
    parameter int COL_LOG  = 1,
    localparam int DATA_W   = 1 << DATA_LOG,
    localparam int COLS_PER = 1 << COL_LOG,
    localparam int ROW_BITS = DATA_W * COLS_PER
) (
    input  logic [ROW_BITS-1:0] row_bits,
    input  logic [COL_LOG-1:0]  col,
    output logic [DATA_W-1:0]   word
);

    // one 2^k:1 selector per bit group
    for (genvar j = 0; j < DATA_W; j++) begin : g_grp
        logic [COLS_PER-1:0] grp;
        assign grp     = row_bits[j*COLS_PER +: COLS_PER];
        assign word[j] = grp[col];
    end

endmodule

// File: rtl/folded_sram.sv
module folded_sram
    import folded_sram_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_LOG = 2,
    parameter int COL_LOG  = 1,
    localparam int DATA_W   = 1 << DATA_LOG,
    localparam int ROW_W    = ADDR_W - COL_LOG,
    localparam int ROWS     = 1 << ROW_W,
    localparam int ROW_BITS = DATA_W * (1 << COL_LOG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [ROWS-1:0]   word_line,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    phase_t state, state_nx;

    logic              accept;
    logic              acc_wr;
    logic              acc_rd;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;
    logic              wl_en;
    logic              arr_we;

    logic [ROW_BITS-1:0] bl;
    logic [DATA_W-1:0]   sensed;

    assign accept = req_valid && (state == PH_PRECH);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_PRECH:  if (accept) state_nx = PH_ACCESS;
            PH_ACCESS: state_nx = PH_PRECH;
            default:   state_nx = PH_PRECH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_PRECH;
        end else begin
            state <= state_nx;
        end
    end

    // phase-dependent outputs
    always_comb begin
        req_ready = 1'b0;
        wl_en     = 1'b0;
        arr_we    = 1'b0;
        unique case (state)
            PH_PRECH:  req_ready = 1'b1;
            PH_ACCESS: begin
                wl_en  = 1'b1;
                arr_we = acc_wr;
            end
            default:   req_ready = 1'b0;
        endcase
    end

    // capture the request for its access phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_wr    <= 1'b0;
            acc_rd    <= 1'b0;
            acc_addr  <= '0;
            acc_wdata <= '0;
        end else if (accept) begin
            acc_wr    <= req_wr;
            acc_rd    <= req_rd;
            acc_addr  <= req_addr;
            acc_wdata <= req_wdata;
        end
    end

    row_predecoder #(.ROW_W(ROW_W)) u_rowdec (
        .en       (wl_en),
        .row_addr (acc_addr[ADDR_W-1:COL_LOG]),
        .wl       (word_line)
    );

    bitline_array #(.ROW_W(ROW_W), .DATA_LOG(DATA_LOG), .COL_LOG(COL_LOG)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .wl    (word_line),
        .we    (arr_we),
        .col   (acc_addr[COL_LOG-1:0]),
        .wdata (acc_wdata),
        .bl    (bl)
    );

    column_mux #(.DATA_LOG(DATA_LOG), .COL_LOG(COL_LOG)) u_colmux (
        .row_bits (bl),
        .col      (acc_addr[COL_LOG-1:0]),
        .word     (sensed)
    );

    // read register: senses the pre-write contents at the end of the access phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state == PH_ACCESS) && acc_rd;
            if ((state == PH_ACCESS) && acc_rd) begin
                rd_data <= sensed;
            end
        end
    end

    // R8
    wl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_ACCESS) |-> ($countones(word_line) == 1));

    // R8
    wl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_PRECH) |-> (word_line == '0));

    // R2
    access_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_ACCESS) |=> (state == PH_PRECH));

    // R4
    rdv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_rd) |=> ##1 rd_valid);

    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((state == PH_ACCESS) && acc_rd) |=> $stable(rd_data));

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_ACCESS) |=> ($stable(acc_addr) && $stable(acc_wdata)));

endmodule

// File: tb/folded_sram_test.sv
`timescale 1ns/1ps
module folded_sram_test;

    localparam int ADDR_W = 3;
    localparam int DW     = 4;
    localparam int ROWS   = 4;
    localparam int WORDS  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_wr = 1'b0;
    logic            req_rd = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            req_ready;
    logic [ROWS-1:0] word_line;
    logic            rd_valid;
    logic [DW-1:0]   rd_data;

    folded_sram uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
        .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .word_line(word_line), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string cur_tag = "R1";

    // behavioural reference
    int ref_mem [WORDS];
    bit ref_busy = 0;
    bit ref_rdv = 0;
    int ref_rdata = 0;
    bit p_wr = 0, p_rd = 0;
    int p_a = 0, p_d = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ref_busy = 0; ref_rdv = 0; ref_rdata = 0;
            foreach (ref_mem[i]) ref_mem[i] = 0;
        end else if (ref_busy) begin
            ref_busy = 0;
            ref_rdv  = p_rd;
            if (p_rd) ref_rdata = ref_mem[p_a];
            if (p_wr) ref_mem[p_a] = p_d;
        end else begin
            ref_rdv = 0;
            if (req_valid) begin
                ref_busy = 1;
                p_wr = req_wr; p_rd = req_rd;
                p_a = int'(req_addr); p_d = int'(req_wdata);
            end
        end
    end

    task automatic check(string tag, int act, int exp, string what);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // compare every output each cycle, away from the rising edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check("R2", int'(req_ready), ref_busy ? 0 : 1, "req_ready");
            check("R8", int'(word_line), ref_busy ? (1 << (p_a >> 1)) : 0, "word_line");
            check("R4", int'(rd_valid), int'(ref_rdv), "rd_valid");
            check(cur_tag, int'(rd_data), ref_rdata, "rd_data");
        end
    end

    // watchdog
    initial begin
        #400000;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // one request: present in the precharge cycle, idle inputs during access
    task automatic issue(bit wr, bit rd, int a, int d);
        @(negedge clk);
        req_valid = 1; req_wr = wr; req_rd = rd;
        req_addr = ADDR_W'(a); req_wdata = DW'(d);
        @(negedge clk);
        req_valid = 0; req_wr = 0; req_rd = 0;
    endtask

    task automatic read_all(string tag);
        cur_tag = tag;
        for (int a = 0; a < WORDS; a++) begin
            issue(0, 1, a, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: ready, quiet word-lines and zeroed storage straight after reset
        check("R1", int'(req_ready), 1, "req_ready after reset");
        check("R1", int'(rd_valid), 0, "rd_valid after reset");
        check("R1", int'(rd_data), 0, "rd_data after reset");
        check("R1", int'(word_line), 0, "word_line after reset");
        read_all("R1");

        // R5: distinct pattern in every word
        cur_tag = "R5";
        for (int a = 0; a < WORDS; a++) begin
            issue(1, 0, a, (a * 5 + 3) & 15);
        end
        read_all("R5");

        // R6: neighbours in the same row stay untouched
        cur_tag = "R6";
        issue(1, 0, 2, 4'hA);
        issue(0, 1, 3, 0);
        issue(1, 0, 7, 4'h0);
        issue(0, 1, 6, 0);
        issue(1, 0, 0, 4'hF);
        issue(0, 1, 1, 0);

        // R7: combined read and write returns the old word
        cur_tag = "R7";
        issue(1, 1, 4, 4'h6);
        issue(0, 1, 4, 0);
        issue(1, 1, 4, 4'h9);
        issue(0, 1, 4, 0);

        // R3: request offered during the access phase is dropped
        cur_tag = "R3";
        @(negedge clk);
        req_valid = 1; req_wr = 1; req_rd = 0; req_addr = 3'd5; req_wdata = 4'hC;
        @(negedge clk);
        req_valid = 1; req_wr = 1; req_rd = 1; req_addr = 3'd6; req_wdata = 4'h3;
        @(negedge clk);
        req_valid = 0; req_wr = 0; req_rd = 0;
        @(negedge clk);
        issue(0, 1, 6, 0);
        issue(0, 1, 5, 0);
        check("R3", int'(rd_valid), 0, "rd_valid between requests");

        // R5: final sweep of every address
        read_all("R5");
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule